// File: doc/BRIEF.md
# SPI Receive Capture Delay Adjuster

This block sits between the pins of an SPI master and its shift register. It adds a programmable number of core clock cycles to three paths: outgoing serial data on its way to the pin, incoming serial data on its way to the shifter, and the strobe that tells the shifter when to sample. At high serial clock rates the round trip through pads and board traces can approach a full bit time. Moving the capture point relative to the returned data lets the receiver recover bits that would otherwise be sampled too early. Software picks the setting. At slow rates it typically delays the incoming data by one to three cycles as the divide ratio grows. At fast rates it moves only the capture point.

The capture point can move earlier or later than nominal, and a register pipeline cannot advance a signal. So the nominal strobe is taken after a fixed base of two cycles, and the incoming data path carries the same two-cycle base as its reference. The "ahead" settings take taps before the nominal one. All delays are flip-flop pipelines clocked by the core clock.

A small controller with three states keeps settings from changing inside a burst. In IDLE the active settings follow the configuration input on every clock. The IDLE→BURST transition happens when `burst_active` is seen high, and the settings are then frozen. BURST→DRAIN happens when `burst_active` is seen low. DRAIN waits for the longest pipeline to empty. DRAIN→BURST happens if a new burst begins before that wait ends, and the old settings are kept. DRAIN→IDLE happens once the wait has lasted the full flush length.

Top module: `spi_capture_adj`

## Requirements
- R1: While reset is asserted, and on the first clock after reset is released, `miso_core` and `sample_adj` are 0 whatever the inputs are. Reset settings are: output delay 0, input delay 0, capture code 2.
- R2: `mosi_pin` equals `mosi_core` delayed by the active output delay field, which is 0 to 3 core cycles (0 means combinational pass-through).
- R3: `miso_core` equals `miso_pin` delayed by 2 plus the active input delay field, which is 2 to 5 core cycles.
- R4: `sample_adj` equals `sample_core` delayed by the active capture code, which is 0 to 3 cycles. Against the two-cycle data base, code 0 samples two cycles ahead, code 1 one cycle ahead, code 2 at nominal and code 3 one cycle late.
- R5: `cfg_word` field positions are: bits [1:0] output delay, bits [3:2] input delay, bits [5:4] capture code.
- R6: Once the controller has entered BURST, changes on `cfg_word` have no effect on any output until the controller is back in IDLE.
- R7: After `burst_active` falls, settings are not reloaded for 5 cycles (the flush length, equal to the deepest pipeline). A burst that restarts within that window runs with the previous settings.
- R8: In IDLE the active settings follow `cfg_word` with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_active | input | 1 | High while the shifter runs a burst |
| cfg_word | input | 6 | Delay settings, field layout per R5 |
| mosi_core | input | 1 | Serial output data from the shifter |
| miso_pin | input | 1 | Raw serial input data from the pad |
| sample_core | input | 1 | Nominal sample strobe from the shifter |
| mosi_pin | output | 1 | Delayed serial output data to the pad |
| miso_core | output | 1 | Delayed serial input data to the shifter |
| sample_adj | output | 1 | Adjusted sample strobe to the shifter |

## Verification
A wrong tap selection shows at once as an output stream shifted by a whole cycle against the driven input history. A scoreboard comparing every cycle catches it on the first input transition that follows. A controller stuck in the wrong state, or a drain counter that ends too early, loads the altered configuration inside a burst. This shows within a few cycles as all three streams moving to the wrong delays. Patterns include extreme settings (all zero, all three) so that the boundary taps are exercised.

// File: rtl/spi_cadj_pkg.sv
package spi_cadj_pkg;

    localparam int FIELD_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DRAIN = 2'd2
    } adj_state_e;

    // packed so that it maps straight onto the configuration word
    typedef struct packed {
        logic [FIELD_W-1:0] cap;
        logic [FIELD_W-1:0] in_d;
        logic [FIELD_W-1:0] out_d;
    } adj_cfg_t;

    localparam int CFG_W = 3 * FIELD_W;

    localparam adj_cfg_t CFG_RESET = '{cap: FIELD_W'(2), in_d: '0, out_d: '0};

endpackage

// File: rtl/spi_cadj_tap_line.sv
module spi_cadj_tap_line #(
    parameter int MAX_DLY = 3,
    parameter int SEL_W   = $clog2(MAX_DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             d,
    input  logic [SEL_W-1:0] sel,
    output logic             q
);

    logic [MAX_DLY:0] taps;

    assign taps[0] = d;

    generate
        for (genvar g = 1; g <= MAX_DLY; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    taps[g] <= 1'b0;
                end else begin
                    taps[g] <= taps[g-1];
                end
            end
        end
    endgenerate

    always_comb begin
        q = taps[MAX_DLY];
        for (int i = 0; i <= MAX_DLY; i++) begin
            if (sel == SEL_W'(i)) begin
                q = taps[i];
            end
        end
    end

endmodule

// File: rtl/spi_cadj_ctrl.sv
module spi_cadj_ctrl #(
    parameter int FLUSH_CYC = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   burst_active,
    input  spi_cadj_pkg::adj_cfg_t cfg_in,
    output spi_cadj_pkg::adj_cfg_t cfg_act
);
    import spi_cadj_pkg::*;

    localparam int CNT_W = $clog2(FLUSH_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FLUSH_CYC - 1);

    adj_state_e       state, state_nx;
    logic [CNT_W-1:0] drain_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (burst_active) state_nx = ST_BURST;
            ST_BURST: if (!burst_active) state_nx = ST_DRAIN;
            ST_DRAIN: begin
                if (burst_active) begin
                    state_nx = ST_BURST;
                end else if (drain_cnt == CNT_LAST) begin
                    state_nx = ST_IDLE;
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs: settings latch and flush counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_act   <= CFG_RESET;
            drain_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cfg_act   <= cfg_in;
                    drain_cnt <= '0;
                end
                ST_DRAIN: drain_cnt <= drain_cnt + 1'b1;
                default:  drain_cnt <= '0;
            endcase
        end
    end

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cfg_act));

    assert_drain_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (drain_cnt < CNT_W'(FLUSH_CYC)));

    assert_idle_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (cfg_act == $past(cfg_in)));

endmodule

// File: rtl/spi_capture_adj.sv
module spi_capture_adj #(
    parameter int BASE_DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       burst_active,
    input  logic [5:0] cfg_word,
    input  logic       mosi_core,
    input  logic       miso_pin,
    input  logic       sample_core,
    output logic       mosi_pin,
    output logic       miso_core,
    output logic       sample_adj
);
    import spi_cadj_pkg::*;

    localparam int FIELD_MAX = (1 << FIELD_W) - 1;
    localparam int MOSI_MAX  = FIELD_MAX;
    localparam int MISO_MAX  = BASE_DLY + FIELD_MAX;
    localparam int SMP_MAX   = FIELD_MAX;
    localparam int MISO_SW   = $clog2(MISO_MAX + 1);

    adj_cfg_t         cfg_in, cfg_act;
    logic [MISO_SW-1:0] miso_sel;

    assign cfg_in   = adj_cfg_t'(cfg_word);
    assign miso_sel = MISO_SW'(BASE_DLY) + MISO_SW'(cfg_act.in_d);

    spi_cadj_ctrl #(.FLUSH_CYC(MISO_MAX)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .burst_active (burst_active),
        .cfg_in       (cfg_in),
        .cfg_act      (cfg_act)
    );

    spi_cadj_tap_line #(.MAX_DLY(MOSI_MAX), .SEL_W(FIELD_W)) u_mosi (
        .clk (clk), .rst_n (rst_n), .d (mosi_core), .sel (cfg_act.out_d), .q (mosi_pin)
    );

    spi_cadj_tap_line #(.MAX_DLY(MISO_MAX), .SEL_W(MISO_SW)) u_miso (
        .clk (clk), .rst_n (rst_n), .d (miso_pin), .sel (miso_sel), .q (miso_core)
    );

    spi_cadj_tap_line #(.MAX_DLY(SMP_MAX), .SEL_W(FIELD_W)) u_smp (
        .clk (clk), .rst_n (rst_n), .d (sample_core), .sel (cfg_act.cap), .q (sample_adj)
    );

    // cycles since reset, so that $past never reaches into reset
    logic [1:0] age;
    logic       age_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 1'b1;
        end
    end
    assign age_ok = (age == 2'd3);

    assert_mosi_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && cfg_act.out_d == 2'd1) |-> (mosi_pin == $past(mosi_core)));

    assert_miso_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && cfg_act.in_d == 2'd0) |-> (miso_core == $past(miso_pin, 2)));

    assert_smp_nominal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_ok && cfg_act.cap == 2'd2) |-> (sample_adj == $past(sample_core, 2)));

endmodule

// File: tb/test_spi_capture_adj.sv
`timescale 1ns/1ps
module test_spi_capture_adj;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       burst_active;
    logic [5:0] cfg_word;
    logic       mosi_core, miso_pin, sample_core;
    logic       mosi_pin, miso_core, sample_adj;

    always #2.5 clk = ~clk;

    spi_capture_adj i_spi_capture_adj (
        .clk (clk), .rst_n (rst_n), .burst_active (burst_active),
        .cfg_word (cfg_word), .mosi_core (mosi_core), .miso_pin (miso_pin),
        .sample_core (sample_core), .mosi_pin (mosi_pin),
        .miso_core (miso_core), .sample_adj (sample_adj)
    );

    typedef struct {
        logic  m;
        logic  i;
        logic  s;
        string tag;
    } exp_t;

    exp_t       sb_q[$];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;
    logic [15:0] lfsr  = 16'hACE1;
    logic [7:0] hm = '0, hi = '0, hs = '0;   // [0] = value driven this cycle
    int         e_out, e_in, e_cap;
    bit         chk_en = 0;
    string      phase  = "";

    task automatic check1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // R5: field positions [1:0] out, [3:2] in, [5:4] capture
    task automatic set_model(input logic [5:0] w);
        e_out = int'(w[1:0]);
        e_in  = int'(w[3:2]);
        e_cap = int'(w[5:4]);
    endtask

    // driver: drives one cycle of stimulus, pushes the expected outputs
    task automatic step();
        exp_t e;
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mosi_core   = lfsr[0];
        miso_pin    = lfsr[5];
        sample_core = lfsr[9];
        hm = {hm[6:0], mosi_core};
        hi = {hi[6:0], miso_pin};
        hs = {hs[6:0], sample_core};
        #1;
        if (chk_en) begin
            e.m   = hm[e_out];
            e.i   = hi[2 + e_in];
            e.s   = hs[e_cap];
            e.tag = phase;
            sb_q.push_back(e);
        end
    endtask

    // monitor: compares after the driver has pushed
    always @(negedge clk) begin
        #2;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check1({e.tag, " mosi R2 R5"},    mosi_pin,   e.m);
            check1({e.tag, " miso R3 R5"},    miso_core,  e.i);
            check1({e.tag, " strobe R4 R5"},  sample_adj, e.s);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] pats [6];
        pats[0] = 6'b10_00_00;
        pats[1] = 6'b00_11_01;
        pats[2] = 6'b01_01_10;
        pats[3] = 6'b11_10_11;
        pats[4] = 6'b00_00_00;
        pats[5] = 6'b11_11_11;

        rst_n = 1'b0; burst_active = 1'b0; cfg_word = 6'b10_00_00;
        mosi_core = 1'b1; miso_pin = 1'b1; sample_core = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check1("reset miso R1",   miso_core,  1'b0);
        check1("reset strobe R1", sample_adj, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check1("post-reset miso R1",   miso_core,  1'b0);
        check1("post-reset strobe R1", sample_adj, 1'b0);

        for (int p = 0; p < 6; p++) begin
            chk_en   = 0;
            cfg_word = pats[p];
            repeat (8) step();
            set_model(pats[p]);
            phase  = "idle R8";
            chk_en = 1;
            repeat (6) step();
            burst_active = 1'b1;
            phase = "burst R6";
            repeat (4) step();
            cfg_word = pats[p] ^ 6'h3F;
            repeat (12) step();
            burst_active = 1'b0;
            phase = "drain R7";
            repeat (2) step();
            burst_active = 1'b1;
            repeat (8) step();
            burst_active = 1'b0;
            repeat (2) step();
        end
        chk_en = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule